// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a programmable compare-match timer. A small register bus sees four word registers. The first is a control/status word. The second is the live up-counter. The third is the compare value. The fourth holds the channel's run bit. The counter does not run on the bus clock. Its count tick comes from a slow reference clock that enters the block as a plain signal. That signal is synchronised into the bus clock domain, edge-detected, and divided by a selectable ratio.

When the counter leaves a value equal to the compare value, the channel records a match. In periodic mode the same tick returns the counter to zero, so the period is the compare value plus one ticks. In free-running mode the counter carries on, and a wrap from all ones to zero records an overflow. The match flag can be routed to an interrupt line or to a DMA request line. A write to the counter lands only after two slow-clock edges. Software therefore loads the counter while the channel is stopped and waits before it starts the channel.

Top module: `cmp_match_timer`

## Requirements
- R1: After reset every register reads 0, the channel is stopped, and `irq_o` and `dma_req_o` are low.
- R2: The control/status word has these fields: bit 15 match flag, bit 14 overflow flag, bit 8 periodic mode, bit 7 interrupt enable, bits 5:4 request routing, bits 2:0 tick select. All other bits read 0, and the two flags ignore the written value except as stated in R3.
- R3: A control/status write with bit 15 at 0 clears the match flag, and with bit 14 at 0 clears the overflow flag. Writing 1 to either flag leaves it unchanged.
- R4: The tick select chooses how many synchronised slow-clock rising edges make one count tick: 4 gives 8, 5 gives 32, 6 gives 128, 7 gives 1. Values 0 to 3 give no ticks.
- R5: In periodic mode, after k ticks from 0 the counter reads k mod (C+1), where C is the compare value. The match flag sets on tick C+1 and not before.
- R6: In free-running mode the counter keeps counting past the compare value and the match flag still sets on that tick. Wrapping from all ones to 0 sets the overflow flag.
- R7: The channel counts only while its run bit is 1, and a stopped channel holds its counter. The run register reads 0 in every bit except the run bit position.
- R8: A counter write takes effect at the second synchronised slow-clock edge after it. Until then the counter reads back its old value.
- R9: Clearing the run bit resets the tick divider, so a restarted channel needs a full divide ratio of edges before its first tick.
- R10: `irq_o` is high when the match flag is set, the interrupt is enabled and routing is 2. `dma_req_o` is high when the match flag is set and routing is 1. Writing 0 to the control/status word drops both lines.
- R11: The registers sit at byte addresses 0 (control/status), 4 (counter), 8 (compare) and 12 (run). Address bits 3:2 select among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | DMA request level |

## Verification
The bench builds the channel with an 8-bit counter and the run bit at position 3. The narrow counter makes the all-ones wrap and its overflow flag reachable within a few slow-clock periods. It also allows a sweep of small compare values through several whole periods each. Each of the four divide ratios and one reserved select is run for enough slow edges to produce a known number of ticks. This includes the divide-by-128 ratio, and it covers the divider restart after a stop.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   localparam int BIT_MATCH    = 15;
   localparam int BIT_OVF      = 14;
   localparam int BIT_PERIODIC = 8;
   localparam int BIT_IRQ_EN   = 7;
   localparam int ROUTE_LSB    = 4;
   localparam int SEL_LSB      = 0;

   // Widest divide ratio is 128, so the prescaler needs 7 bits.
   localparam int PRESC_W = 7;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_DMA  = 2'd1,
      ROUTE_IRQ  = 2'd2,
      ROUTE_RSVD = 2'd3
   } route_e;

   typedef enum logic [1:0] {
      REG_CSR = 2'd0,
      REG_CNT = 2'd1,
      REG_CMP = 2'd2,
      REG_RUN = 2'd3
   } reg_e;

   typedef struct packed {
      logic       periodic;
      logic       irq_en;
      route_e     route;
      logic [2:0] sel;
   } ctrl_t;

   // Returns {valid, terminal prescaler count} for a tick select value.
   function automatic logic [PRESC_W:0] tick_term(input logic [2:0] sel);
      case (sel)
         3'd4:    return {1'b1, 7'd7};
         3'd5:    return {1'b1, 7'd31};
         3'd6:    return {1'b1, 7'd127};
         3'd7:    return {1'b1, 7'd0};
         default: return {1'b0, 7'd0};
      endcase
   endfunction

endpackage

// File: rtl/cmt_tick_sync.sv
module cmt_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic edge_o
);

   initial begin
      AST_CFG_SYNC_DEPTH: assert (STAGES >= 2); // R8
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign edge_o = sync_q[STAGES-1] & ~prev_q;

   AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |=> !edge_o); // R4

endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
   import cmt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       edge_i,
   input  logic [2:0] sel_i,
   output logic       tick_o
);

   logic [PRESC_W-1:0] presc_q;
   logic [PRESC_W-1:0] term;
   logic               valid;
   logic               wrap;

   assign {valid, term} = tick_term(sel_i);
   assign wrap          = run_i && edge_i && valid && (presc_q >= term);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         presc_q <= '0;
      else if (!run_i)
         presc_q <= '0;
      else if (edge_i && valid)
         presc_q <= wrap ? '0 : presc_q + 1'b1;
   end

   assign tick_o = wrap;

   AST_PRESC_CLEARED_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (presc_q == '0)); // R9

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             slow_edge_i,
   input  logic             periodic_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             flag_wr_i,
   input  logic             match_keep_i,
   input  logic             ovf_keep_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o,
   output logic             ovf_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pend_val_q;
   logic [1:0]       pend_q;
   logic             load;
   logic             hit;
   logic             match_q;
   logic             ovf_q;
   logic             match_set;
   logic             ovf_set;

   assign load      = slow_edge_i && (pend_q == 2'd1) && !cnt_wr_i;
   assign hit       = (cnt_q == cmp_i);
   assign match_set = tick_i && !load && hit;
   assign ovf_set   = tick_i && !load && !periodic_i && (&cnt_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q     <= 2'd0;
         pend_val_q <= '0;
      end else if (cnt_wr_i) begin
         pend_q     <= 2'd2;
         pend_val_q <= cnt_wdata_i;
      end else if (slow_edge_i && pend_q != 2'd0) begin
         pend_q     <= pend_q - 2'd1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load)
         cnt_q <= pend_val_q;
      else if (tick_i)
         cnt_q <= (periodic_i && hit) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         match_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         match_q <= match_set | (match_q & ~(flag_wr_i & ~match_keep_i));
         ovf_q   <= ovf_set   | (ovf_q   & ~(flag_wr_i & ~ovf_keep_i));
      end
   end

   assign cnt_o   = cnt_q;
   assign match_o = match_q;
   assign ovf_o   = ovf_q;

   AST_FROZEN_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !load) |=> $stable(cnt_q)); // R7
   AST_MATCH_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(match_q) |-> $past(tick_i)); // R5
   AST_OVF_LANDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_q) |-> (cnt_q == '0)); // R6
   AST_LOAD_NOT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_wr_i |=> !load); // R8

endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer
   import cmt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int RUN_BIT     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              slow_clk_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              dma_req_o
);

   initial begin
      AST_CFG_DATA_W: assert (DATA_W >= 16); // R2
      AST_CFG_CNT_W:  assert (CNT_W >= 2 && CNT_W <= DATA_W); // R11
      AST_CFG_ADDR_W: assert (ADDR_W >= 4); // R11
      AST_CFG_RUN:    assert (RUN_BIT >= 0 && RUN_BIT < DATA_W); // R7
   end

   reg_e             reg_sel;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic             run_q;
   logic             slow_edge;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             match;
   logic             ovf;
   logic             wr_csr;
   logic             wr_cnt;
   logic [DATA_W-1:0] cnt_ext;
   logic [DATA_W-1:0] cmp_ext;
   logic             unused_bits;

   assign reg_sel     = reg_e'(bus_addr_i[3:2]);
   assign wr_csr      = bus_wr_i && (reg_sel == REG_CSR);
   assign wr_cnt      = bus_wr_i && (reg_sel == REG_CNT);
   assign unused_bits = ^{bus_addr_i, bus_wdata_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
         run_q  <= 1'b0;
      end else if (bus_wr_i) begin
         case (reg_sel)
            REG_CSR: begin
               ctrl_q.periodic <= bus_wdata_i[BIT_PERIODIC];
               ctrl_q.irq_en   <= bus_wdata_i[BIT_IRQ_EN];
               ctrl_q.route    <= route_e'(bus_wdata_i[ROUTE_LSB +: 2]);
               ctrl_q.sel      <= bus_wdata_i[SEL_LSB +: 3];
            end
            REG_CMP: cmp_q <= bus_wdata_i[CNT_W-1:0];
            REG_RUN: run_q <= bus_wdata_i[RUN_BIT];
            default: ;
         endcase
      end
   end

   cmt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (slow_clk_i),
      .edge_o  (slow_edge)
   );

   cmt_prescaler u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .edge_i (slow_edge),
      .sel_i  (ctrl_q.sel),
      .tick_o (tick)
   );

   cmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick),
      .slow_edge_i  (slow_edge),
      .periodic_i   (ctrl_q.periodic),
      .cmp_i        (cmp_q),
      .cnt_wr_i     (wr_cnt),
      .cnt_wdata_i  (bus_wdata_i[CNT_W-1:0]),
      .flag_wr_i    (wr_csr),
      .match_keep_i (bus_wdata_i[BIT_MATCH]),
      .ovf_keep_i   (bus_wdata_i[BIT_OVF]),
      .cnt_o        (cnt),
      .match_o      (match),
      .ovf_o        (ovf)
   );

   generate
      if (CNT_W < DATA_W) begin : g_pad
         assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
         assign cmp_ext = {{(DATA_W-CNT_W){1'b0}}, cmp_q};
      end else begin : g_full
         assign cnt_ext = cnt;
         assign cmp_ext = cmp_q;
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      case (reg_sel)
         REG_CSR: begin
            bus_rdata_o[BIT_MATCH]         = match;
            bus_rdata_o[BIT_OVF]           = ovf;
            bus_rdata_o[BIT_PERIODIC]      = ctrl_q.periodic;
            bus_rdata_o[BIT_IRQ_EN]        = ctrl_q.irq_en;
            bus_rdata_o[ROUTE_LSB +: 2]    = ctrl_q.route;
            bus_rdata_o[SEL_LSB +: 3]      = ctrl_q.sel;
         end
         REG_CNT: bus_rdata_o = cnt_ext;
         REG_CMP: bus_rdata_o = cmp_ext;
         REG_RUN: bus_rdata_o[RUN_BIT] = run_q;
         default: ;
      endcase
   end

   assign irq_o     = match && ctrl_q.irq_en && (ctrl_q.route == ROUTE_IRQ);
   assign dma_req_o = match && (ctrl_q.route == ROUTE_DMA);

   AST_REQ_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({irq_o, dma_req_o})); // R10
   AST_CSR_ZERO_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_csr && bus_wdata_i[15:0] == 16'h0 && !tick) |=> (!irq_o && !dma_req_o)); // R10

endmodule

// File: tb/cmp_match_timer_test.sv
module cmp_match_timer_test;

   localparam int DW  = 32;
   localparam int CW  = 8;
   localparam int RB  = 3;
   localparam logic [3:0] A_CSR = 4'd0;
   localparam logic [3:0] A_CNT = 4'd4;
   localparam logic [3:0] A_CMP = 4'd8;
   localparam logic [3:0] A_RUN = 4'd12;
   localparam logic [31:0] RUN_ON = 32'h1 << RB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow = 1'b0;
   logic [3:0]    addr = '0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          dma;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cmp_match_timer #(.DATA_W(DW), .CNT_W(CW), .ADDR_W(4), .RUN_BIT(RB), .SYNC_STAGES(2)) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .slow_clk_i  (slow),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq),
      .dma_req_o   (dma)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) slow = 1'b1;
         repeat (6) @(negedge clk);
         slow = 1'b0;
         repeat (6) @(negedge clk);
      end
   endtask

   task automatic load_cnt(input logic [31:0] v);
      bus_wr(A_CNT, v);
      pulses(2);
   endtask

   task automatic div_case(input logic [2:0] sel, input int n, input int exp_ticks);
      logic [31:0] d;
      bus_wr(A_RUN, 0);
      bus_wr(A_CSR, {29'd0, sel});
      bus_wr(A_CMP, 32'hFF);
      load_cnt(0);
      bus_wr(A_RUN, RUN_ON);
      pulses(n);
      bus_rd(A_CNT, d); chk("R4 divided tick count", d, exp_ticks);
      bus_wr(A_RUN, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(A_CSR, d); chk("R1 csr reset", d, 0);
      bus_rd(A_CNT, d); chk("R1 cnt reset", d, 0);
      bus_rd(A_CMP, d); chk("R1 cmp reset", d, 0);
      bus_rd(A_RUN, d); chk("R1 run reset", d, 0);
      chk("R1 irq reset", irq, 0);
      chk("R1 dma reset", dma, 0);

      // R7 R11 run register sits at byte 12, only the run bit reads back
      bus_wr(A_RUN, 32'hFFFF_FFFF);
      bus_rd(A_RUN, d); chk("R7 run readback", d, RUN_ON);
      bus_wr(A_RUN, 0);
      bus_wr(A_CMP, 32'h1234_56A5);
      bus_rd(A_CMP, d); chk("R11 cmp at byte 8", d, 32'hA5);

      // R2 reserved bits read 0, flags unaffected by writing 1
      bus_wr(A_CSR, 32'hFFFF_FFFF);
      bus_rd(A_CSR, d); chk("R2 csr field layout", d, 32'h0000_01B7);
      chk("R10 route 3 gives no request", {irq, dma}, 0);
      bus_wr(A_CSR, 0);

      // R8 counter write lands after two slow edges
      bus_wr(A_CNT, 32'h2A);
      bus_rd(A_CNT, d); chk("R8 old value right after write", d, 0);
      pulses(1);
      bus_rd(A_CNT, d); chk("R8 old value after one edge", d, 0);
      pulses(1);
      bus_rd(A_CNT, d); chk("R8 new value after two edges", d, 32'h2A);

      // R7 stopped channel holds its counter
      bus_wr(A_CSR, 32'h7);
      pulses(3);
      bus_rd(A_CNT, d); chk("R7 frozen while stopped", d, 32'h2A);

      // R5 periodic sweep over small compare values
      for (int c = 0; c <= 4; c++) begin
         bus_wr(A_RUN, 0);
         bus_wr(A_CSR, 32'h0107);
         bus_wr(A_CMP, c);
         load_cnt(0);
         bus_wr(A_RUN, RUN_ON);
         for (int k = 1; k <= 2 * (c + 1); k++) begin
            pulses(1);
            bus_rd(A_CNT, d); chk("R5 periodic count", d, k % (c + 1));
            if (k == c) begin
               bus_rd(A_CSR, d); chk("R5 no match before period end", d, 32'h0107);
            end
         end
         bus_rd(A_CSR, d); chk("R5 match flag after period", d, 32'h8107);
      end
      bus_wr(A_RUN, 0);

      // R6 free-running: counts past compare and sets match
      bus_wr(A_CSR, 32'h0007);
      bus_wr(A_CMP, 3);
      load_cnt(0);
      bus_wr(A_RUN, RUN_ON);
      pulses(3);
      bus_rd(A_CSR, d); chk("R6 no match yet", d, 32'h0007);
      pulses(2);
      bus_rd(A_CNT, d); chk("R6 counts past compare", d, 5);
      bus_rd(A_CSR, d); chk("R6 match in free-running", d, 32'h8007);

      // R10 request routing with match flag held
      bus_wr(A_CSR, 32'h80A7);
      chk("R10 irq route", {irq, dma}, 2'b10);
      bus_wr(A_CSR, 32'h8017);
      chk("R10 dma route", {irq, dma}, 2'b01);
      bus_wr(A_CSR, 32'h8027);
      chk("R10 irq route without enable", {irq, dma}, 2'b00);
      bus_wr(A_CSR, 32'h8087);
      chk("R10 no route", {irq, dma}, 2'b00);
      bus_wr(A_CSR, 32'h80A7);
      bus_wr(A_CSR, 0);
      chk("R10 zero write drops requests", {irq, dma}, 2'b00);
      bus_rd(A_CSR, d); chk("R3 zero write clears match", d, 0);
      bus_wr(A_RUN, 0);

      // R6 overflow on wrap
      bus_wr(A_CSR, 32'h0007);
      bus_wr(A_CMP, 32'h10);
      load_cnt(32'hFC);
      bus_wr(A_RUN, RUN_ON);
      pulses(3);
      bus_rd(A_CNT, d); chk("R6 at all ones", d, 32'hFF);
      bus_rd(A_CSR, d); chk("R6 no overflow before wrap", d, 32'h0007);
      pulses(1);
      bus_rd(A_CNT, d); chk("R6 wrapped to zero", d, 0);
      bus_rd(A_CSR, d); chk("R6 overflow set", d, 32'h4007);
      bus_wr(A_RUN, 0);

      // R3 write-one keeps, write-zero clears
      bus_wr(A_CSR, 32'hC007);
      bus_rd(A_CSR, d); chk("R3 write one keeps overflow", d, 32'h4007);
      bus_wr(A_CSR, 32'h8007);
      bus_rd(A_CSR, d); chk("R3 write zero clears overflow", d, 32'h0007);

      // R4 divide ratios and a reserved select
      div_case(3'd4, 20, 2);
      div_case(3'd5, 70, 2);
      div_case(3'd6, 130, 1);
      div_case(3'd7, 9, 9);
      div_case(3'd0, 10, 0);

      // R9 divider restarts after a stop
      bus_wr(A_CSR, 32'h0004);
      load_cnt(0);
      bus_wr(A_RUN, RUN_ON);
      pulses(5);
      bus_wr(A_RUN, 0);
      bus_wr(A_RUN, RUN_ON);
      pulses(5);
      bus_rd(A_CNT, d); chk("R9 no tick after restart", d, 0);
      pulses(3);
      bus_rd(A_CNT, d); chk("R9 tick after full ratio", d, 1);
      bus_wr(A_RUN, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule